// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a 12-bit converter. A processor or other source writes a code into a two-part input latch: an 8-bit upper part and a 4-bit lower part. A separate transfer strobe later copies the assembled word into the converter register, whose contents are the block's output code. Because the two stages are separate, the next code can be loaded while the present one stays on the output. Several converters that share one transfer line can then update together, or an outside device can decide when a new code takes effect.

All controls are active-low levels, except the byte-select line. A synchronous clock samples them every cycle, and every stage whose enable is active captures its new value on that edge. A parameter chooses the bus. In the narrow mode the bus is 8 bits wide and carries left-justified data in two writes: the upper byte first, then a nibble in the top four bus lines. In the wide mode the bus is 12 bits wide and carries the word in one write.

There are three ways to use the transfer. The first is automatic: the second write also strobes the transfer, so the word reaches the output as its low nibble is written. The second and third are processor-controlled and externally strobed: a separate decode or device drives the transfer later. In the wide mode, holding every control low with byte-select high makes the block follow the bus, one clock behind.

Top module: `dbuf_dac_front`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low, the input latch and the output code become zero on each clock edge. A transfer right after reset therefore outputs zero.
- R2: The input latch changes only on an edge where `sel_n` and `wr_a_n` are both low. At every other edge it keeps its value.
- R3: An input write with `hi_byte` high loads all 12 latch bits. In wide mode, latch bit i takes `din[i]`. In narrow mode, latch bits 11..4 take `din[7:0]` and latch bits 3..0 take `din[7:4]`.
- R4: An input write with `hi_byte` low replaces only latch bits 3..0 and leaves bits 11..4 unchanged. The source is `din[3:0]` in wide mode and `din[7:4]` in narrow mode. In narrow mode `din[3:0]` has no effect.
- R5: `code` changes only on an edge where `wr_b_n` and `xfer_n` are both low. With either of them high, an input write leaves `code` unchanged.
- R6: On an edge where `wr_b_n` and `xfer_n` are both low, `code` takes the value the input latch holds after that same edge. This includes a write made on that edge, which gives automatic transfer.
- R7: In wide mode, with all four active-low controls low and `hi_byte` high, `code` equals the `din` value sampled at the previous clock edge.
- R8: In narrow mode, a high-byte write of B followed by a low write of N and a transfer gives `code` = {B, N[7:4]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Select for the input write, active low |
| wr_a_n | input | 1 | Input-latch write strobe, active low |
| wr_b_n | input | 1 | Transfer enable strobe, active low |
| xfer_n | input | 1 | Transfer strobe, active low |
| hi_byte | input | 1 | High: write all 12 latch bits; low: write only the low nibble |
| din | input | DIN_W (12 wide, 8 narrow) | Data bus |
| code | output | CODE_W (12) | Converter register contents |

## Verification
The properties assume that every control and data input is driven to a known level from the first edge after reset. They also assume that the four active-low controls change only between clock edges, so each edge sees one whole command. The bench drives every input from its declaration or at the falling edge. It holds reset low from time zero until the first rising edge, and it never leaves a control undriven. The flow-through property relies on the wide-bus parameter. It is therefore only generated for that variant, and the narrow instance is checked through its latch and transfer properties alone.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
   // decoded per-cycle enables for the two storage stages
   typedef struct packed {
      logic load_hi;
      logic load_lo;
      logic xfer;
   } dac_en_t;

   localparam int unsigned DEF_CODE_W = 12;
   localparam int unsigned DEF_HI_W   = 8;
endpackage

// File: rtl/dac_ctl_decode.sv
module dac_ctl_decode
   import dac_front_pkg::*;
(
   input  logic    sel_n,
   input  logic    wr_a_n,
   input  logic    wr_b_n,
   input  logic    xfer_n,
   input  logic    hi_byte,
   output dac_en_t en
);
   logic wr_ok;

   always_comb begin
      wr_ok      = ~sel_n & ~wr_a_n;
      en.load_lo = wr_ok;
      en.load_hi = wr_ok & hi_byte;
      en.xfer    = ~wr_b_n & ~xfer_n;
   end
endmodule

// File: rtl/dac_in_latch.sv
module dac_in_latch
   import dac_front_pkg::*;
#(
   parameter int unsigned CODE_W   = DEF_CODE_W,
   parameter int unsigned HI_W     = DEF_HI_W,
   parameter bit          WIDE_BUS = 1'b1,
   localparam int unsigned LO_W    = CODE_W - HI_W,
   localparam int unsigned DIN_W   = WIDE_BUS ? CODE_W : HI_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  dac_en_t           en,
   input  logic [DIN_W-1:0]  din,
   output logic [CODE_W-1:0] word_nxt,
   output logic [CODE_W-1:0] word_q
);
   logic [HI_W-1:0] hi_src, hi_q, hi_nxt;
   logic [LO_W-1:0] lo_src, lo_q, lo_nxt;

   generate
      if (WIDE_BUS) begin : g_wide
         always_comb begin
            hi_src = din[CODE_W-1:LO_W];
            lo_src = din[LO_W-1:0];
         end
      end else begin : g_narrow
         // left-justified: the nibble rides on the top lines of the byte
         logic unused_low_lines;
         always_comb begin
            hi_src = din[HI_W-1:0];
            lo_src = din[HI_W-1:HI_W-LO_W];
         end
         if (HI_W > LO_W) begin : g_spare
            assign unused_low_lines = ^din[HI_W-LO_W-1:0];
         end else begin : g_nospare
            assign unused_low_lines = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      hi_nxt   = en.load_hi ? hi_src : hi_q;
      lo_nxt   = en.load_lo ? lo_src : lo_q;
      word_nxt = {hi_nxt, lo_nxt};
      word_q   = {hi_q, lo_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         hi_q <= hi_nxt;
         lo_q <= lo_nxt;
      end
   end
endmodule

// File: rtl/dac_hold_reg.sv
module dac_hold_reg #(
   parameter int unsigned CODE_W = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] d,
   output logic [CODE_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/dbuf_dac_front.sv
module dbuf_dac_front
   import dac_front_pkg::*;
#(
   parameter int unsigned CODE_W   = DEF_CODE_W,
   parameter int unsigned HI_W     = DEF_HI_W,
   parameter bit          WIDE_BUS = 1'b1,
   localparam int unsigned LO_W    = CODE_W - HI_W,
   localparam int unsigned DIN_W   = WIDE_BUS ? CODE_W : HI_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              wr_a_n,
   input  logic              wr_b_n,
   input  logic              xfer_n,
   input  logic              hi_byte,
   input  logic [DIN_W-1:0]  din,
   output logic [CODE_W-1:0] code
);
   initial begin
      if (HI_W < 1 || HI_W >= CODE_W)
         $fatal(1, "dbuf_dac_front: HI_W must lie in 1..CODE_W-1");
      if (LO_W > HI_W)
         $fatal(1, "dbuf_dac_front: low part must fit inside the narrow bus");
   end

   dac_en_t           en;
   logic [CODE_W-1:0] in_nxt;
   logic [CODE_W-1:0] in_word;

   dac_ctl_decode u_dec (
      .sel_n   (sel_n),
      .wr_a_n  (wr_a_n),
      .wr_b_n  (wr_b_n),
      .xfer_n  (xfer_n),
      .hi_byte (hi_byte),
      .en      (en)
   );

   dac_in_latch #(
      .CODE_W   (CODE_W),
      .HI_W     (HI_W),
      .WIDE_BUS (WIDE_BUS)
   ) u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .din      (din),
      .word_nxt (in_nxt),
      .word_q   (in_word)
   );

   // the transfer sees the latch value of the same edge: transparent chain
   dac_hold_reg #(
      .CODE_W (CODE_W)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (en.xfer),
      .d     (in_nxt),
      .q     (code)
   );
endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk #(
   parameter int unsigned CODE_W   = 12,
   parameter int unsigned DIN_W    = 12,
   parameter int unsigned LO_W     = 4,
   parameter bit          WIDE_BUS = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              sel_n,
   input logic              wr_a_n,
   input logic              wr_b_n,
   input logic              xfer_n,
   input logic              hi_byte,
   input logic [DIN_W-1:0]  din,
   input logic [CODE_W-1:0] in_word,
   input logic [CODE_W-1:0] code
);
   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (code == '0 && in_word == '0));

   // R2
   a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n || wr_a_n) |=> $stable(in_word));

   // R4
   a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !wr_a_n && !hi_byte) |=> $stable(in_word[CODE_W-1:LO_W]));

   // R5
   a_r5_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b_n || xfer_n) |=> $stable(code));

   // R6
   a_r6_xfer_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_b_n && !xfer_n) |=> (code == in_word));

   generate
      if (WIDE_BUS) begin : g_flow
         // R7
         a_r7_flow_through: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n && !wr_a_n && !wr_b_n && !xfer_n && hi_byte)
               |=> (code == $past(din)));
      end
   endgenerate
endmodule

bind dbuf_dac_front dac_front_chk #(
   .CODE_W   (CODE_W),
   .DIN_W    (DIN_W),
   .LO_W     (LO_W),
   .WIDE_BUS (WIDE_BUS)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_n   (sel_n),
   .wr_a_n  (wr_a_n),
   .wr_b_n  (wr_b_n),
   .xfer_n  (xfer_n),
   .hi_byte (hi_byte),
   .din     (din),
   .in_word (in_word),
   .code    (code)
);

// File: tb/dbuf_dac_front_tb_top.sv
module dbuf_dac_front_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, wr_a_n = 1'b1, wr_b_n = 1'b1, xfer_n = 1'b1, hi_byte = 1'b1;
   logic [11:0] w_din = '0;
   logic [7:0]  n_din = '0;
   logic [11:0] w_code, n_code;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbuf_dac_front #(.WIDE_BUS(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_a_n(wr_a_n),
      .wr_b_n(wr_b_n), .xfer_n(xfer_n), .hi_byte(hi_byte),
      .din(w_din), .code(w_code)
   );

   dbuf_dac_front #(.WIDE_BUS(1'b0)) dut_n8_i (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_a_n(wr_a_n),
      .wr_b_n(wr_b_n), .xfer_n(xfer_n), .hi_byte(hi_byte),
      .din(n_din), .code(n_code)
   );

   // {sel_n, wr_a_n, wr_b_n, xfer_n, hi_byte} , din , expected code after the edge
   localparam logic [28:0] VEC [NVEC] = '{
      {5'b00111, 12'hA5C, 12'h000},
      {5'b11111, 12'hFFF, 12'h000},
      {5'b11001, 12'h123, 12'hA5C},
      {5'b00110, 12'h7F3, 12'hA5C},
      {5'b11001, 12'h000, 12'hA53},
      {5'b00111, 12'h3C9, 12'hA53},
      {5'b11011, 12'h456, 12'hA53},
      {5'b11101, 12'h456, 12'hA53},
      {5'b10111, 12'h111, 12'hA53},
      {5'b01111, 12'h222, 12'hA53},
      {5'b11001, 12'h000, 12'h3C9},
      {5'b00000, 12'h00E, 12'h3CE},
      {5'b00001, 12'h804, 12'h804},
      {5'b00001, 12'hFFF, 12'hFFF},
      {5'b00001, 12'h000, 12'h000}
   };
   localparam string VTAG [NVEC] = '{
      "R3", "R2", "R6", "R4", "R4", "R3", "R5", "R5",
      "R2", "R2", "R2", "R6", "R7", "R7", "R7"
   };

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at the falling edge, then step past the next rising edge
   task automatic step(input logic [4:0] ctl, input logic [11:0] wd, input logic [7:0] nd);
      @(negedge clk);
      {sel_n, wr_a_n, wr_b_n, xfer_n, hi_byte} = ctl;
      w_din = wd;
      n_din = nd;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 wide reset", w_code, 12'h000);
      check("R1 narrow reset", n_code, 12'h000);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][28:24], VEC[i][23:12], 8'h00);
         check(VTAG[i], w_code, VEC[i][11:0]);
      end

      // narrow bus, left-justified two-write sequence
      @(negedge clk);
      rst_n = 1'b0;
      step(5'b11111, 12'h000, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      step(5'b00111, 12'h000, 8'hB7);
      check("R5 narrow no xfer", n_code, 12'h000);
      step(5'b11001, 12'h000, 8'h00);
      check("R3 narrow high write", n_code, 12'hB7B);
      step(5'b00110, 12'h000, 8'h4F);
      check("R4 narrow low write holds code", n_code, 12'hB7B);
      step(5'b11001, 12'h000, 8'h00);
      check("R8 narrow assembled word", n_code, 12'hB74);
      step(5'b00110, 12'h000, 8'h40);
      step(5'b11001, 12'h000, 8'h00);
      check("R4 narrow low lines ignored", n_code, 12'hB74);
      step(5'b00000, 12'h000, 8'h2A);
      check("R6 narrow automatic transfer", n_code, 12'hB72);

      // reset in mid-run clears both stages
      step(5'b00001, 12'h9E1, 8'h00);
      check("R7 wide flow before reset", w_code, 12'h9E1);
      @(negedge clk);
      rst_n = 1'b0;
      {sel_n, wr_a_n, wr_b_n, xfer_n, hi_byte} = 5'b11111;
      @(posedge clk);
      #1;
      check("R1 wide mid reset", w_code, 12'h000);
      check("R1 narrow mid reset", n_code, 12'h000);
      @(negedge clk);
      rst_n = 1'b1;
      step(5'b11001, 12'h000, 8'h00);
      check("R1 wide latch cleared", w_code, 12'h000);
      check("R1 narrow latch cleared", n_code, 12'h000);

      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end
endmodule